// File: doc/BRIEF.md
# Multiplexed LCD Scan Timing Generator

This block scans a multiplexed dot-matrix character panel. It drives one common row at a time and holds the segment dots for that row on a latched 40-bit output. While a row is on the glass, the block fetches the dots of the next row one per clock from an external pattern lookup and shifts them into a shift register. At the row boundary it copies the shift register into the output latch and moves the common select on by one.

Dots beyond the block's own segments go out serially to cascaded column drivers, together with a shift strobe and a row latch strobe. An alternation output flips once per frame so that the panel sees AC drive. The frame pattern is set by a line-count bit and a font-height bit. The display-enable, cursor and blink inputs change the dots that are shown.

The lookup is addressed by a display address and a font row. It returns five pattern bits, with bit 4 as the leftmost dot column. The display address is the character position plus a shift offset, folded into the line length. The shift offset must be smaller than the line length.

Top module: `lcd_scan_timer`

## Requirements
- R1: The number of common rows per frame is 8 in one-line mode with the small font, 11 in one-line mode with the tall font, and COM_N (16) in two-line mode. Rows advance 0,1,...,n-1 and then wrap to 0. If a mode change leaves the current row at or beyond the new last row, the next row is 0.
- R2: `row_latch` pulses once per row period. The period is LONG_PER clocks in both one-line modes and SHORT_PER clocks in two-line mode.
- R3: Exactly one bit of `com_out` is high at any time, and it is the bit of the row whose dots are on `seg_out`. After reset it is bit 0.
- R4: Bit k of `seg_out` is dot k of the displayed row. Dot k belongs to character k/5, at dot column k%5, and takes its value from `pat_bits[4 - k%5]`.
- R5: For character c, the display address is (c + `shift_ofs`) mod L. L is LINE1 (80) in one-line mode and LINE2 (40) in two-line mode. In two-line mode, rows COM_N/2 and above add 0x40 to the address and use a font row of row - COM_N/2. Otherwise the font row equals the row.
- R6: Dots SEG_W to SEG_W+EXT_W-1 of each row leave on `ext_data` in ascending order. There is one dot per cycle, with `ext_shift` high for exactly EXT_W cycles per row, and these cycles never coincide with `row_latch`.
- R7: `alt_m` is 0 after reset. It toggles at the boundary where the row wraps to 0 and at no other time.
- R8: While `disp_on` is 0, `seg_out` and `ext_data` are 0. The latched dots are kept, so `seg_out` shows them again in the cycle `disp_on` returns to 1.
- R9: With `cursor_on` set, every dot of the underline row is forced to 1 for the character whose display address equals `cursor_addr`. The underline row is font row 10 in one-line tall-font mode and font row 7 otherwise.
- R10: A blink phase starts at 0 after reset and flips after every BLINK_FR completed frames. While `blink_on` is set and the phase is 1, all dots of the cursor character are 1. A row uses the phase in force while it was fetched, which is the row period before it is shown.
- R11: During reset, `seg_out` is 0, `com_out` is 1 and `alt_m` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_line | input | 1 | 1 selects two-line mode, which scans COM_N rows |
| big_font | input | 1 | 1 selects the 11-row font in one-line mode |
| disp_on | input | 1 | Display enable |
| cursor_on | input | 1 | Underline cursor enable |
| blink_on | input | 1 | Blinking block cursor enable |
| shift_ofs | input | 7 | Display shift offset in characters |
| cursor_addr | input | 7 | Display address of the cursor |
| pat_bits | input | 5 | Pattern row returned by the lookup for `ram_addr`/`font_row`; bit 4 is the leftmost dot |
| ram_addr | output | 7 | Display address being fetched |
| font_row | output | $clog2(COM_N) | Font row being fetched |
| seg_out | output | SEG_W | Latched segment dots |
| com_out | output | COM_N | One-hot common row select |
| ext_data | output | 1 | Serial dot data for the cascaded driver |
| ext_shift | output | 1 | High in each cycle that carries a valid `ext_data` bit |
| row_latch | output | 1 | One-cycle strobe at the end of each row period |
| alt_m | output | 1 | Frame alternation signal |

## Verification
The embedded assertions check four properties on every cycle:
- the common select stays one-hot;
- the output latch and the alternation signal change only at a row boundary;
- every row carries exactly EXT_W extension strobes;
- no strobe overlaps the latch pulse.

Only the bench scenarios can show that the dot values are right. This covers:
- the address folding, including the modulo wrap at high shift offsets;
- the second-line offset and the underline row for each font;
- the blink phase lagging by one fetch period;
- the row count and the period for each mode;
- the wrap rule when the duty shrinks under a high row.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int SEG_W      = 40,
  parameter int EXT_W      = 80,
  parameter int COM_N      = 16,
  parameter int ROWS_SMALL = 8,
  parameter int ROWS_BIG   = 11,
  parameter int LONG_PER   = 400,
  parameter int SHORT_PER  = 200,
  parameter int LINE1      = 80,
  parameter int LINE2      = 40,
  parameter int BLINK_FR   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       two_line,
  input  logic                       big_font,
  input  logic                       disp_on,
  input  logic                       cursor_on,
  input  logic                       blink_on,
  input  logic [6:0]                 shift_ofs,
  input  logic [6:0]                 cursor_addr,
  input  logic [4:0]                 pat_bits,
  output logic [6:0]                 ram_addr,
  output logic [$clog2(COM_N)-1:0]   font_row,
  output logic [SEG_W-1:0]           seg_out,
  output logic [COM_N-1:0]           com_out,
  output logic                       ext_data,
  output logic                       ext_shift,
  output logic                       row_latch,
  output logic                       alt_m
);
  localparam int DOTS = SEG_W + EXT_W;
  localparam int PW   = $clog2((LONG_PER > SHORT_PER) ? LONG_PER : SHORT_PER);
  localparam int CHW  = $clog2(DOTS / 5 + 1);
  localparam int RW   = $clog2(COM_N) + 1;
  localparam int FW   = $clog2(BLINK_FR) + 1;
  localparam int HALF = COM_N / 2;

  logic [PW-1:0]    ph;
  logic [CHW-1:0]   chr;
  logic [2:0]       col;
  logic [RW-1:0]    row;
  logic [COM_N-1:0] com_q;
  logic [SEG_W-1:0] sr, lat;
  logic             m_q, blink_q;
  logic [FW-1:0]    fcnt;

  wire [RW-1:0] nrows = two_line ? RW'(COM_N) : (big_font ? RW'(ROWS_BIG) : RW'(ROWS_SMALL));
  wire [PW-1:0] per   = two_line ? PW'(SHORT_PER) : PW'(LONG_PER);
  wire          bnd   = ph >= per - 1'b1;
  wire          wrap  = row >= nrows - 1'b1;
  wire [RW-1:0] nxt   = wrap ? '0 : row + 1'b1;
  wire          line2 = two_line && (nxt >= RW'(HALF));
  wire [RW-1:0] frow  = line2 ? nxt - RW'(HALF) : nxt;

  wire [7:0] len = two_line ? 8'(LINE2) : 8'(LINE1);
  wire [7:0] s0  = 8'(chr) + {1'b0, shift_ofs};
  wire [7:0] s1  = (s0 >= len) ? s0 - len : s0;
  wire [7:0] s2  = (s1 >= len) ? s1 - len : s1;

  assign ram_addr = s2[6:0] + (line2 ? 7'h40 : 7'h00);
  assign font_row = frow[RW-2:0];

  wire          hit    = ram_addr == cursor_addr;
  wire [RW-1:0] ul_row = (!two_line && big_font) ? RW'(ROWS_BIG - 1) : RW'(ROWS_SMALL - 1);
  wire          dot    = pat_bits[3'd4 - col]
                       | (hit && blink_on && blink_q)
                       | (hit && cursor_on && frow == ul_row);

  wire in_seg = ph < PW'(SEG_W);
  wire in_ext = (ph >= PW'(SEG_W)) && (ph < PW'(DOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; chr <= '0; col <= '0; row <= '0;
      com_q <= COM_N'(1); sr <= '0; lat <= '0;
      m_q <= 1'b0; blink_q <= 1'b0; fcnt <= '0;
    end else if (bnd) begin
      ph <= '0; chr <= '0; col <= '0;
      lat <= sr;
      row <= nxt;
      com_q <= wrap ? COM_N'(1) : com_q << 1;
      if (wrap) begin
        m_q <= ~m_q;
        if (fcnt == FW'(BLINK_FR - 1)) begin
          fcnt <= '0;
          blink_q <= ~blink_q;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end
    end else begin
      ph <= ph + 1'b1;
      if (ph < PW'(DOTS)) begin
        if (col == 3'd4) begin
          col <= '0;
          chr <= chr + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
      if (in_seg) sr <= {dot, sr[SEG_W-1:1]};
    end
  end

  assign seg_out   = disp_on ? lat : '0;
  assign com_out   = com_q;
  assign ext_shift = in_ext;
  assign ext_data  = in_ext && dot && disp_on;
  assign row_latch = bnd;
  assign alt_m     = m_q;

  logic [PW-1:0] sh_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || bnd) sh_cnt <= '0;
    else if (ext_shift) sh_cnt <= sh_cnt + 1'b1;
  end

  // R3
  com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_out) == 1);

  // R7
  alt_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_latch |=> $stable(alt_m));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_latch |=> $stable(lat));

  // R6
  ext_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |-> sh_cnt == PW'(EXT_W));

  // R6
  ext_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_shift |-> !row_latch);
endmodule

// File: tb/test_lcd_scan_timer.sv
module test_lcd_scan_timer;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W = 40;
  localparam int EXT_W = 10;
  localparam int DOTS  = SEG_W + EXT_W;
  localparam int LP    = 64;
  localparam int SP    = 56;
  localparam int BF    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_line = 1'b0, big_font = 1'b0, disp_on = 1'b1, cursor_on = 1'b0, blink_on = 1'b0;
  logic [6:0] shift_ofs = '0, cursor_addr = 7'h7f;
  logic [4:0] pat_bits;
  logic [6:0] ram_addr;
  logic [3:0] font_row;
  logic [SEG_W-1:0] seg_out;
  logic [15:0] com_out;
  logic ext_data, ext_shift, row_latch, alt_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] pat_fn(int a, int r);
    int v;
    v = (a * 7) ^ (r * 11) ^ (a >> 2);
    return v[4:0];
  endfunction

  assign pat_bits = pat_fn(int'(ram_addr), int'(font_row));

  lcd_scan_timer #(.SEG_W(SEG_W), .EXT_W(EXT_W), .COM_N(16), .ROWS_SMALL(8), .ROWS_BIG(11),
                   .LONG_PER(LP), .SHORT_PER(SP), .LINE1(80), .LINE2(40), .BLINK_FR(BF))
  i_lcd_scan_timer (
    .clk(clk), .rst_n(rst_n), .two_line(two_line), .big_font(big_font), .disp_on(disp_on),
    .cursor_on(cursor_on), .blink_on(blink_on), .shift_ofs(shift_ofs), .cursor_addr(cursor_addr),
    .pat_bits(pat_bits), .ram_addr(ram_addr), .font_row(font_row), .seg_out(seg_out),
    .com_out(com_out), .ext_data(ext_data), .ext_shift(ext_shift), .row_latch(row_latch),
    .alt_m(alt_m));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [SEG_W-1:0] q_seg[$];
  logic [EXT_W-1:0] q_ext[$];
  int               q_row[$];
  bit               q_m[$];
  int               q_per[$];
  string            q_tag[$];
  int pending = 0;

  int  m_row = 0, m_fcnt = 0;
  bit  m_m = 0, m_bph = 0, first_item = 1, prev_on = 1;
  logic [SEG_W-1:0] last_raw = '0;

  function automatic logic [DOTS-1:0] row_dots(int fr, bit two, bit big, int sh, int ca,
                                              bit cur, bit blk, bit bph);
    logic [DOTS-1:0] d;
    for (int p = 0; p < DOTS; p++) begin
      int pos, cl, frow, len, a, ul;
      bit ln;
      logic [4:0] pt;
      pos = p / 5; cl = p % 5;
      ln = two && (fr >= 8);
      frow = ln ? fr - 8 : fr;
      len = two ? 40 : 80;
      a = ((pos + sh) % len) + (ln ? 64 : 0);
      pt = pat_fn(a, frow);
      d[p] = pt[4 - cl];
      ul = (!two && big) ? 10 : 7;
      if (a == ca && blk && bph) d[p] = 1'b1;
      if (a == ca && cur && frow == ul) d[p] = 1'b1;
    end
    return d;
  endfunction

  task automatic run(input bit two, input bit big, input bit on, input bit cur, input bit blk,
                     input int sh, input int ca, input int n, input string tag);
    int nrows;
    #1;
    two_line = two; big_font = big; disp_on = on; cursor_on = cur; blink_on = blk;
    shift_ofs = 7'(sh); cursor_addr = 7'(ca);
    #1;
    if (on && !prev_on)
      chk(seg_out == last_raw, "R8 restore", 64'(seg_out), 64'(last_raw));
    prev_on = on;
    nrows = two ? 16 : (big ? 11 : 8);
    for (int i = 0; i < n; i++) begin
      int nr;
      bit wr;
      logic [DOTS-1:0] d;
      wr = m_row >= nrows - 1;
      nr = wr ? 0 : m_row + 1;
      d = row_dots(nr, two, big, sh, ca, cur, blk, m_bph);
      if (wr) begin
        m_m = ~m_m;
        if (m_fcnt == BF - 1) begin m_fcnt = 0; m_bph = ~m_bph; end
        else m_fcnt++;
      end
      m_row = nr;
      last_raw = d[SEG_W-1:0];
      q_seg.push_back(on ? d[SEG_W-1:0] : '0);
      q_ext.push_back(on ? d[DOTS-1:SEG_W] : '0);
      q_row.push_back(nr);
      q_m.push_back(m_m);
      q_per.push_back(first_item ? 0 : (two ? SP : LP));
      q_tag.push_back(tag);
      first_item = 0;
    end
    pending += n;
    wait (pending == 0);
  endtask

  logic [EXT_W-1:0] ext_cap = '0;
  int ecnt = 0, cyc = 0, last_lat = 0, meas = 0;
  bit seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (seen) begin
        if (q_seg.size() == 0) begin
          chk(1'b0, "R2 unexpected row boundary", 64'(cyc), 64'(0));
        end else begin
          logic [SEG_W-1:0] es;
          logic [EXT_W-1:0] ee;
          int er, ep;
          bit em;
          string tg;
          es = q_seg.pop_front(); ee = q_ext.pop_front(); er = q_row.pop_front();
          em = q_m.pop_front(); ep = q_per.pop_front(); tg = q_tag.pop_front();
          chk(seg_out == es, {tg, " seg"}, 64'(seg_out), 64'(es));
          chk(com_out == 16'(1 << er), "R1 R3 com", 64'(com_out), 64'(1 << er));
          chk(alt_m == em, "R7 alt", 64'(alt_m), 64'(em));
          chk(ecnt == EXT_W && ext_cap == ee, "R6 ext", 64'(ext_cap), 64'(ee));
          if (ep != 0) chk(meas == ep, "R2 period", 64'(meas), 64'(ep));
          pending--;
        end
        ecnt = 0;
        ext_cap = '0;
      end
      if (ext_shift) begin
        if (ecnt < EXT_W) ext_cap[ecnt] = ext_data;
        ecnt++;
      end
      seen = row_latch;
      if (row_latch) begin
        meas = cyc - last_lat;
        last_lat = cyc;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk(seg_out == '0, "R11 seg", 64'(seg_out), 64'(0));
    chk(com_out == 16'h1, "R11 com", 64'(com_out), 64'(1));
    chk(alt_m == 1'b0, "R11 alt", 64'(alt_m), 64'(0));
    rst_n = 1'b1;
    run(0, 0, 1, 0, 0, 0, 127, 20, "R4");
    run(0, 1, 1, 1, 0, 5, 7, 24, "R9");
    run(1, 0, 1, 1, 0, 3, 'h42, 34, "R5");
    run(0, 0, 1, 0, 1, 0, 2, 40, "R10");
    run(0, 0, 0, 0, 0, 1, 127, 10, "R8");
    run(0, 0, 1, 0, 0, 1, 127, 6, "R8");
    run(0, 0, 1, 0, 0, 75, 127, 10, "R5");
    run(1, 0, 1, 1, 1, 39, 'h40, 20, "R5");
    run(0, 1, 1, 0, 0, 0, 127, 12, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", pending, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule